// File: doc/BRIEF.md
# Flash Interface Mode Controller

This block is the control state machine that sits behind the pins of a byte-wide parallel flash front end. It tracks the operating mode of the device and decides three things. It decides whether the device reports busy. It decides whether the data pins may drive. It decides which source a read returns: the memory array, the identification code register, or the operation status bits. The memory array, the cell timing and the program/erase engine are outside the block. Writes reach the block as abstract 4-bit command tokens. The engine reports completion with a single-cycle done pulse.

The device hardware reset input is qualified by a minimum pulse width counted in clock cycles. A qualified pulse does the following:

- It aborts any running operation.
- It returns the block to array read.
- If an operation was in flight, it keeps the busy flag high through a recovery period after the pin is released.

While the pin is low, the outputs are disabled and all writes are ignored. An accelerate input forces the two-token program mode and overrides sector protection for as long as it is held.

Top module: `flash_mode_ctrl`

## Requirements
- R1: When `hw_reset_n` is sampled low on RST_MIN consecutive clock edges, the block returns to array read with `rd_src` = 0 (array). A shorter low pulse leaves the current mode unchanged, including autoselect and a running operation.
- R2: While `hw_reset_n` is low, `drive_en` is 0. Every token written in that time is ignored, including one that would otherwise advance an unlock sequence.
- R3: A qualified reset during a running operation works as follows:
  - `busy` stays 1 through the pulse.
  - `busy` stays 1 for exactly REC_CYC edges after the first edge that samples the pin high.
  - The aborted operation is not resumed: a later `engine_done` has no effect.
  - A qualified reset taken while idle never raises `busy`.
- R4: The tokens UNLK_A (1), UNLK_B (2), ID_ENTER (3) switch reads to the code register (`rd_src` = 1). Other tokens are ignored in that mode. RET_READ (11) returns to array read.
- R5: In normal mode the tokens UNLK_A, UNLK_B, PROG_SETUP (4), PROG_DATA (5) start a program: `busy` rises after the last token, and an `engine_done` pulse returns the block to array read.
- R6: A token that does not continue the current unlock sequence returns the sequence to its start. A later partial sequence then has no effect.
- R7: The tokens UNLK_A, UNLK_B, BYP_ENTER (9) enter the two-token program mode. In that mode PROG_SETUP then PROG_DATA start a program, and the mode persists across completed programs. BYP_EXIT (10) leaves it.
- R8: While `accel` is 1, the block is in the two-token program mode and a program proceeds even when `prot_hit` is 1. Dropping `accel` returns the block to normal mode, after the running program if one is in flight.
- R9: Without `accel`, a program or sector erase whose final token arrives with `prot_hit` = 1 is ignored and `busy` stays 0.
- R10: Erase works as follows:
  - UNLK_A, UNLK_B, ERASE_SETUP (6), UNLK_A, UNLK_B, ERASE_SECT (7) open a sector collection window of SECT_WIN edges, with `busy` = 1.
  - Each further unprotected ERASE_SECT restarts the window.
  - `engine_done` is ignored until the window closes.
  - ERASE_ALL (8) in place of ERASE_SECT starts a whole-device erase at once.
- R11: Whenever `busy` is 1, `rd_src` is 2 (status).
- R12: `drive_en` equals `chip_sel` AND `rd_en` AND `hw_reset_n` in the same cycle. Deselecting the chip while busy does not end the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| hw_reset_n | input | 1 | Device hardware reset pin level, active low, synchronous to clk |
| chip_sel | input | 1 | Chip selected (active high) |
| rd_en | input | 1 | Output enable request (active high) |
| cmd_valid | input | 1 | Write strobe for one command token |
| cmd_code | input | 4 | Command token code |
| prot_hit | input | 1 | Addressed sector is protected |
| accel | input | 1 | Accelerate level (stands in for the high-voltage pin) |
| engine_done | input | 1 | Single-cycle completion pulse from the program/erase engine |
| busy | output | 1 | Operation in progress or reset recovery |
| drive_en | output | 1 | Data pins may drive |
| rd_src | output | 2 | Read source: 0 array, 1 code register, 2 status |

## Verification
The bench targets the following corner cases:

- **Edge counts at every reset boundary.** A pulse one edge short of the minimum must not abort anything. A full-length pulse during a program must keep `busy` high for exactly the recovery count. A design that is off by one edge flips a check at a known cycle.
- **Closing edge of the erase window.** A done pulse landing on the window's closing edge must be ignored, as must one landing just before a restarted window closes. A design that lets the engine finish during collection drops `busy` too early.
- **Mode persistence and exit.** Two-token programs must repeat until exit, and releasing `accel` mid-program must fall back to normal mode only after completion.
- **Writes dropped during a reset pulse.** Tokens written while the reset pin is low must not advance an unlock sequence.
- **Random traffic.** A constrained-random section checks the output enable against the pin levels and confirms that stray tokens never leave array read.

// File: rtl/flash_mode_pkg.sv
package flash_mode_pkg;

  typedef enum logic [3:0] {
    TK_NONE        = 4'd0,
    TK_UNLK_A      = 4'd1,
    TK_UNLK_B      = 4'd2,
    TK_ID_ENTER    = 4'd3,
    TK_PROG_SETUP  = 4'd4,
    TK_PROG_DATA   = 4'd5,
    TK_ERASE_SETUP = 4'd6,
    TK_ERASE_SECT  = 4'd7,
    TK_ERASE_ALL   = 4'd8,
    TK_BYP_ENTER   = 4'd9,
    TK_BYP_EXIT    = 4'd10,
    TK_RET_READ    = 4'd11
  } tok_e;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_CODES  = 2'd1,
    SRC_STATUS = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    MD_READ, MD_AUTOSEL, MD_BYPASS, MD_ERWIN, MD_BUSY, MD_RESET, MD_RECOVER
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_U1, PH_U2, PH_PD, PH_E1, PH_E2, PH_E3
  } phase_e;

  typedef struct packed {
    logic autosel;
    logic prog;
    logic erase_sect;
    logic erase_all;
    logic byp_enter;
    logic byp_exit;
    logic ret_read;
  } cmd_ev_t;

endpackage

// File: rtl/flash_rst_qual.sv
module flash_rst_qual #(
  parameter int RST_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_reset_n,
  output logic rst_fire
);
  localparam int CW = $clog2(RST_MIN + 1);

  logic [CW-1:0] lo_cnt_q, lo_cnt_d;
  logic          lo_cnt_en;

  // One-cycle pulse on the edge that completes the minimum low width.
  assign rst_fire = !hw_reset_n && (lo_cnt_q == CW'(RST_MIN - 1));

  always_comb begin
    lo_cnt_en = 1'b0;
    lo_cnt_d  = lo_cnt_q;
    if (hw_reset_n) begin
      lo_cnt_en = (lo_cnt_q != '0);
      lo_cnt_d  = '0;
    end else if (lo_cnt_q != CW'(RST_MIN)) begin
      lo_cnt_en = 1'b1;
      lo_cnt_d  = lo_cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt_q <= '0;
    end else if (lo_cnt_en) begin
      lo_cnt_q <= lo_cnt_d;
    end
  end

  // R1: a held-low pin qualifies once, not on every following cycle
  a_r1_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fire |=> !rst_fire);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_ok,
  input  logic [3:0] tok,
  input  logic       in_read,
  input  logic       in_bypass,
  input  logic       clr,
  output cmd_ev_t    ev
);
  phase_e ph_q, ph_d;
  tok_e   tk;

  assign tk = tok_e'(tok);

  always_comb begin
    ev   = '0;
    ph_d = ph_q;
    if (tok_ok) begin
      ph_d = PH_IDLE;
      if (in_read) begin
        case (ph_q)
          PH_IDLE: begin
            if (tk == TK_UNLK_A)        ph_d = PH_U1;
            else if (tk == TK_RET_READ) ev.ret_read = 1'b1;
          end
          PH_U1: if (tk == TK_UNLK_B) ph_d = PH_U2;
          PH_U2: begin
            if (tk == TK_ID_ENTER)         ev.autosel   = 1'b1;
            else if (tk == TK_PROG_SETUP)  ph_d         = PH_PD;
            else if (tk == TK_ERASE_SETUP) ph_d         = PH_E1;
            else if (tk == TK_BYP_ENTER)   ev.byp_enter = 1'b1;
          end
          PH_PD: if (tk == TK_PROG_DATA) ev.prog = 1'b1;
          PH_E1: if (tk == TK_UNLK_A) ph_d = PH_E2;
          PH_E2: if (tk == TK_UNLK_B) ph_d = PH_E3;
          PH_E3: begin
            if (tk == TK_ERASE_SECT)     ev.erase_sect = 1'b1;
            else if (tk == TK_ERASE_ALL) ev.erase_all  = 1'b1;
          end
          default: ph_d = PH_IDLE;
        endcase
      end else if (in_bypass) begin
        if (ph_q == PH_PD) begin
          if (tk == TK_PROG_DATA) ev.prog = 1'b1;
        end else if (tk == TK_PROG_SETUP) begin
          ph_d = PH_PD;
        end else if (tk == TK_BYP_EXIT) begin
          ev.byp_exit = 1'b1;
        end
      end else if (tk == TK_RET_READ) begin
        ev.ret_read = 1'b1;
      end
    end
    if (clr) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  // R6: only the first unlock token can leave the idle phase in normal mode
  a_r6_unlock_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_ok && in_read && ph_q == PH_IDLE && tok != 4'd1) |=> ph_q == PH_IDLE);

  // R7: in the two-token mode the setup token arms the data phase directly
  a_r7_bypass_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_ok && in_bypass && !in_read && ph_q == PH_IDLE && tok == 4'd4 && !clr)
      |=> ph_q == PH_PD);

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import flash_mode_pkg::*;
#(
  parameter int RST_MIN  = 4,
  parameter int REC_CYC  = 6,
  parameter int SECT_WIN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_reset_n,
  input  logic       chip_sel,
  input  logic       rd_en,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       prot_hit,
  input  logic       accel,
  input  logic       engine_done,
  output logic       busy,
  output logic       drive_en,
  output logic [1:0] rd_src
);
  localparam int CNT_MAX = (REC_CYC > SECT_WIN) ? REC_CYC : SECT_WIN;
  localparam int CNTW    = $clog2(CNT_MAX + 1);

  mode_e          mode_q, mode_d;
  logic           pend_q, pend_d;
  logic           byacc_q, byacc_d;
  logic           retbyp_q, retbyp_d;
  logic [CNTW-1:0] cnt_q;
  logic           cnt_ld, cnt_inc;

  logic    rst_fire;
  logic    tok_ok, sect_tok, prot_blk, seq_clr;
  cmd_ev_t ev;
  src_e    src;

  flash_rst_qual #(.RST_MIN(RST_MIN)) u_rstq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hw_reset_n (hw_reset_n),
    .rst_fire   (rst_fire)
  );

  // Tokens are accepted only in a settled command-taking mode with the pin high.
  assign tok_ok = cmd_valid && chip_sel && hw_reset_n
                  && !(accel && mode_q != MD_BYPASS)
                  && !(mode_q == MD_BYPASS && byacc_q && !accel)
                  && (mode_q inside {MD_READ, MD_AUTOSEL, MD_BYPASS});
  assign sect_tok = cmd_valid && chip_sel && hw_reset_n && !prot_hit
                    && (cmd_code == TK_ERASE_SECT);
  assign prot_blk = prot_hit && !accel;
  assign seq_clr  = (mode_d != mode_q);

  flash_cmd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_ok    (tok_ok),
    .tok       (cmd_code),
    .in_read   (mode_q == MD_READ),
    .in_bypass (mode_q == MD_BYPASS),
    .clr       (seq_clr),
    .ev        (ev)
  );

  assign busy = (mode_q inside {MD_ERWIN, MD_BUSY, MD_RECOVER})
                || (mode_q == MD_RESET && pend_q);

  always_comb begin
    if (busy)                    src = SRC_STATUS;
    else if (mode_q == MD_AUTOSEL) src = SRC_CODES;
    else                         src = SRC_ARRAY;
  end
  assign rd_src   = src;
  assign drive_en = hw_reset_n && chip_sel && rd_en;

  // Next-state process
  always_comb begin
    mode_d   = mode_q;
    pend_d   = pend_q;
    byacc_d  = byacc_q;
    retbyp_d = retbyp_q;
    cnt_ld   = 1'b0;
    cnt_inc  = 1'b0;
    if (rst_fire) begin
      mode_d   = MD_RESET;
      pend_d   = busy;
      byacc_d  = 1'b0;
      retbyp_d = 1'b0;
    end else begin
      case (mode_q)
        MD_RESET: begin
          if (hw_reset_n) begin
            mode_d = pend_q ? MD_RECOVER : MD_READ;
            pend_d = 1'b0;
            cnt_ld = 1'b1;
          end
        end
        MD_RECOVER: begin
          if (cnt_q == CNTW'(REC_CYC - 1)) mode_d = MD_READ;
          else                             cnt_inc = 1'b1;
        end
        MD_READ: begin
          if (accel) begin
            mode_d  = MD_BYPASS;
            byacc_d = 1'b1;
          end else if (ev.autosel) begin
            mode_d = MD_AUTOSEL;
          end else if (ev.prog && !prot_blk) begin
            mode_d   = MD_BUSY;
            retbyp_d = 1'b0;
          end else if (ev.erase_all) begin
            mode_d   = MD_BUSY;
            retbyp_d = 1'b0;
          end else if (ev.erase_sect && !prot_blk) begin
            mode_d   = MD_ERWIN;
            retbyp_d = 1'b0;
            cnt_ld   = 1'b1;
          end else if (ev.byp_enter) begin
            mode_d  = MD_BYPASS;
            byacc_d = 1'b0;
          end
        end
        MD_AUTOSEL: begin
          if (accel) begin
            mode_d  = MD_BYPASS;
            byacc_d = 1'b1;
          end else if (ev.ret_read) begin
            mode_d = MD_READ;
          end
        end
        MD_BYPASS: begin
          if (byacc_q && !accel) begin
            mode_d = MD_READ;
          end else if (!byacc_q && ev.byp_exit) begin
            mode_d = MD_READ;
          end else if (ev.prog && !prot_blk) begin
            mode_d   = MD_BUSY;
            retbyp_d = 1'b1;
          end
        end
        MD_ERWIN: begin
          if (sect_tok)                         cnt_ld  = 1'b1;
          else if (cnt_q == CNTW'(SECT_WIN - 1)) mode_d  = MD_BUSY;
          else                                  cnt_inc = 1'b1;
        end
        MD_BUSY: begin
          if (engine_done) begin
            if (retbyp_q && (!byacc_q || accel)) mode_d = MD_BYPASS;
            else                                 mode_d = MD_READ;
          end
        end
        default: mode_d = MD_READ;
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_READ;
      pend_q   <= 1'b0;
      byacc_q  <= 1'b0;
      retbyp_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      pend_q   <= pend_d;
      byacc_q  <= byacc_d;
      retbyp_q <= retbyp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= '0;
    end else if (cnt_inc) begin
      cnt_q <= cnt_q + CNTW'(1);
    end
  end

  // R3: qualifying a reset while an operation runs keeps busy asserted
  a_r3_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_fire && mode_q == MD_BUSY) |=> busy);

  // R1: leaving an idle reset lands in array read with busy low
  a_r1_reset_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RESET && hw_reset_n && !pend_q) |=> (mode_q == MD_READ && !busy));

  // R2: no token moves the mode while the reset pin is low
  a_r2_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_reset_n && mode_q == MD_READ && !accel && !rst_fire) |=> mode_q == MD_READ);

  // R12: deselecting the chip does not end a running operation
  a_r12_deselect_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BUSY && !chip_sel && !engine_done && !rst_fire) |=> busy);

  // R8: accelerate forces the two-token mode out of array read
  a_r8_accel_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_READ && accel && !rst_fire) |=> mode_q == MD_BYPASS);

endmodule

// File: tb/sim_flash_mode_ctrl.sv
`timescale 1ns/1ps
module sim_flash_mode_ctrl;
  localparam int RST_MIN  = 4;
  localparam int REC_CYC  = 6;
  localparam int SECT_WIN = 5;

  logic       clk = 1'b0;
  logic       rst_n, hw_reset_n, chip_sel, rd_en, cmd_valid;
  logic [3:0] cmd_code;
  logic       prot_hit, accel, engine_done;
  logic       busy, drive_en;
  logic [1:0] rd_src;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flash_mode_ctrl #(.RST_MIN(RST_MIN), .REC_CYC(REC_CYC), .SECT_WIN(SECT_WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .chip_sel(chip_sel),
    .rd_en(rd_en), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .prot_hit(prot_hit),
    .accel(accel), .engine_done(engine_done), .busy(busy), .drive_en(drive_en),
    .rd_src(rd_src)
  );

  function automatic logic exp_drive(input logic s, input logic r, input logic h);
    return s & r & h;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [3:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    step(1);
    cmd_valid = 1'b0;
    cmd_code  = 4'd0;
  endtask

  task automatic unl();
    wr(4'd1);
    wr(4'd2);
  endtask

  task automatic done_pulse();
    engine_done = 1'b1;
    step(1);
    engine_done = 1'b0;
  endtask

  task automatic start_prog();
    unl();
    wr(4'd4);
    wr(4'd5);
  endtask

  task automatic start_sect_erase();
    unl();
    wr(4'd6);
    unl();
    wr(4'd7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; hw_reset_n = 1'b1; chip_sel = 1'b1; rd_en = 1'b0;
    cmd_valid = 1'b0; cmd_code = 4'd0; prot_hit = 1'b0; accel = 1'b0;
    engine_done = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);

    chk("R12 reset busy", busy, 0);
    chk("R12 reset src", rd_src, 0);
    chk("R12 reset drive", drive_en, 0);
    rd_en = 1'b1; #1;
    chk("R12 drive on", drive_en, 1);

    // R4 autoselect
    unl(); wr(4'd3);
    chk("R4 codes selected", rd_src, 1);
    wr(4'd4);
    chk("R4 other token ignored", rd_src, 1);
    chk("R4 no busy", busy, 0);
    wr(4'd11);
    chk("R4 return to array", rd_src, 0);

    // R6 broken sequences
    wr(4'd1); wr(4'd3); wr(4'd2); wr(4'd3);
    chk("R6 broken unlock", rd_src, 0);
    wr(4'd1); wr(4'd1); wr(4'd2); wr(4'd3);
    chk("R6 repeated first token", rd_src, 0);

    // R5 / R11 / R12 normal program, deselect while busy
    start_prog();
    chk("R5 program busy", busy, 1);
    chk("R11 status source", rd_src, 2);
    chip_sel = 1'b0;
    step(3); #1;
    chk("R12 deselected stays busy", busy, 1);
    chk("R12 deselected no drive", drive_en, 0);
    chip_sel = 1'b1;
    done_pulse();
    chk("R5 done idles", busy, 0);
    chk("R5 back to array", rd_src, 0);

    // R9 protection
    prot_hit = 1'b1;
    start_prog();
    chk("R9 protected program ignored", busy, 0);
    start_sect_erase();
    chk("R9 protected erase ignored", busy, 0);
    prot_hit = 1'b0;

    // R10 chip erase
    unl(); wr(4'd6); unl(); wr(4'd8);
    chk("R10 chip erase busy", busy, 1);
    done_pulse();
    chk("R10 chip erase done", busy, 0);

    // R10 window closing edge
    start_sect_erase();
    chk("R10 window busy", busy, 1);
    step(SECT_WIN - 1);
    done_pulse();
    chk("R10 done on closing edge ignored", busy, 1);
    done_pulse();
    chk("R10 done after window", busy, 0);

    // R10 window restart
    start_sect_erase();
    step(1);
    wr(4'd7);
    step(SECT_WIN - 2);
    done_pulse();
    chk("R10 restarted window ignores done", busy, 1);
    step(1);
    done_pulse();
    chk("R10 restarted window ends", busy, 0);

    // R7 command bypass
    unl(); wr(4'd9);
    chk("R7 bypass entry not busy", busy, 0);
    chk("R7 bypass array source", rd_src, 0);
    wr(4'd4); wr(4'd5);
    chk("R7 two-token program", busy, 1);
    done_pulse();
    chk("R7 program done", busy, 0);
    wr(4'd4); wr(4'd5);
    chk("R7 bypass persists", busy, 1);
    done_pulse();
    wr(4'd10); wr(4'd4); wr(4'd5);
    chk("R7 exit restores unlock", busy, 0);

    // R8 accelerate
    accel = 1'b1;
    step(1);
    prot_hit = 1'b1;
    wr(4'd4); wr(4'd5);
    chk("R8 accel program on protected", busy, 1);
    prot_hit = 1'b0;
    accel = 1'b0;
    step(1);
    chk("R8 busy kept after accel drop", busy, 1);
    done_pulse();
    chk("R8 done", busy, 0);
    wr(4'd4); wr(4'd5);
    chk("R8 normal mode after accel", busy, 0);
    unl(); wr(4'd3);
    chk("R8 autoselect before accel", rd_src, 1);
    accel = 1'b1;
    step(1);
    chk("R8 accel leaves autoselect", rd_src, 0);
    accel = 1'b0;
    step(1);

    // R2 tokens ignored during a short low pulse
    hw_reset_n = 1'b0; #1;
    chk("R2 tristate on reset", drive_en, 0);
    wr(4'd1); wr(4'd2);
    hw_reset_n = 1'b1;
    wr(4'd3);
    chk("R2 tokens dropped", rd_src, 0);

    // R1 short pulse during program is not an abort
    start_prog();
    hw_reset_n = 1'b0;
    step(RST_MIN - 1);
    hw_reset_n = 1'b1;
    step(REC_CYC + 2);
    chk("R1 short pulse keeps busy", busy, 1);
    done_pulse();
    chk("R1 op completes", busy, 0);

    // R3 abort during program
    start_prog();
    hw_reset_n = 1'b0;
    step(RST_MIN);
    chk("R3 busy in pulse", busy, 1);
    wr(4'd1);
    hw_reset_n = 1'b1;
    step(1);
    chk("R3 busy at release", busy, 1);
    step(REC_CYC - 1);
    chk("R3 busy last recovery cycle", busy, 1);
    step(1);
    chk("R3 busy released", busy, 0);
    chk("R1 array after abort", rd_src, 0);
    done_pulse();
    chk("R3 not resumed", busy, 0);
    wr(4'd2); wr(4'd3);
    chk("R2 token in pulse dropped", rd_src, 0);

    // R1 / R3 qualified reset while idle in autoselect
    unl(); wr(4'd3);
    hw_reset_n = 1'b0;
    step(RST_MIN - 1);
    hw_reset_n = 1'b1;
    step(1);
    chk("R1 short pulse keeps autoselect", rd_src, 1);
    hw_reset_n = 1'b0;
    step(RST_MIN + 2);
    chk("R3 idle reset no busy", busy, 0);
    hw_reset_n = 1'b1;
    step(1);
    chk("R3 idle release no busy", busy, 0);
    chk("R1 idle reset to array", rd_src, 0);

    // R6 / R12 random traffic
    for (int i = 0; i < 400; i++) begin
      chip_sel  = 1'($urandom_range(0, 1));
      rd_en     = 1'($urandom_range(0, 1));
      cmd_valid = 1'($urandom_range(0, 1));
      cmd_code  = 4'($urandom_range(2, 15));
      #1;
      chk("R12 random drive", drive_en, int'(exp_drive(chip_sel, rd_en, hw_reset_n)));
      step(1);
      chk("R6 random stray tokens", {busy, rd_src}, 0);
    end
    cmd_valid = 1'b0;

    summary();
    $finish;
  end

endmodule